// File: doc/BRIEF.md
# Protected-Mode Selector Translator

This block turns a 16-bit segment selector and a 16-bit offset into a 24-bit linear address. The selector picks an 8-byte descriptor from one of two tables in memory: a global table or a per-task local table. The block reads the descriptor over a simple synchronous read port and takes the segment base, limit, minimum privilege and write permission from it. It then returns either the base-plus-offset address or a 2-bit fault code that names the first rule the access broke.

A request is accepted with a one-cycle `reqValid` while the block is idle. Selector faults (a null global selector, or a local index past the programmed local-table limit) are reported the next cycle and no memory is read. All other requests fetch four descriptor words in consecutive cycles and finish with a one-cycle `done` strobe. While the block is busy it ignores new requests.

Top module: `sel_translate`

## Requirements
- R1: The selector splits as index = bits [15:3], table bit = bit [2] (1 picks the local table at `ldtBase`, 0 the global table at `gdtBase`), and requested privilege = bits [1:0].
- R2: The descriptor is read as four 16-bit words at table base + index×8 + 0, 2, 4 and 6, one request per cycle in consecutive cycles. Read data is taken from `memData` in the cycle after the request.
- R3: The descriptor words are laid out as follows. Word 0 is the limit. Word 1 is base[15:0]. Word 2 holds base[23:16] in bits [7:0], the writable flag in bit 9 and the minimum privilege in bits [14:13]. Word 3 is read but ignored.
- R4: When no rule is broken, `linAddr` = base + offset modulo 2^24 and `faultCode` = 0.
- R5: If the larger of `curPriv` and the requested privilege is numerically greater than the descriptor's minimum privilege, `faultCode` = 1 and `linAddr` = 0.
- R6: A write access (`accWrite` = 1) to a descriptor whose writable flag is 0 gives `faultCode` = 1 and `linAddr` = 0. A read of the same descriptor succeeds.
- R7: An offset greater than the limit gives `faultCode` = 2 and `linAddr` = 0. An offset equal to the limit is allowed.
- R8: A selector with index 0 and table bit 0 gives `faultCode` = 3 with `done` in the cycle after acceptance, and no memory read is made.
- R9: A local-table selector whose index exceeds `ldtLimit` gives `faultCode` = 3 with `done` in the cycle after acceptance, and no memory read is made. An index equal to `ldtLimit` is allowed.
- R10: A fetching request raises `busy` from the cycle after acceptance until it completes, and `done` rises 6 cycles after the acceptance edge. `reqValid` is ignored while `busy` is high.
- R11: Fault priority is selector fault (3) first, then privilege or write fault (1), then limit fault (2).
- R12: After reset, `busy`, `memReq`, `done`, `faultCode` and `linAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| selector | input | 16 | Segment selector |
| offset | input | 16 | Offset within the segment |
| curPriv | input | 2 | Current privilege level (0 is most privileged) |
| accWrite | input | 1 | 1 for a write access |
| gdtBase | input | 24 | Byte base of the global table |
| ldtBase | input | 24 | Byte base of the local table |
| ldtLimit | input | 13 | Highest valid local-table index |
| busy | output | 1 | Descriptor fetch in progress |
| memReq | output | 1 | Memory read request |
| memAddr | output | 24 | Memory read byte address |
| memData | input | 16 | Read data, valid the cycle after `memReq` |
| done | output | 1 | Result strobe |
| faultCode | output | 2 | 0 ok, 1 privilege/write, 2 limit, 3 selector |
| linAddr | output | 24 | Linear address, 0 on any fault |

## Verification
The bench checks the limit boundary on both sides, offset equal to the limit and one past it. A design that used `>=` would reject a legal last byte. It also checks the local-table limit at the limit and past it, and a base-plus-offset sum that wraps past 2^24. Privilege is violated once through the requested level and once through the current level, which catches a design that compares only one of them. A segment that breaks both the privilege and the limit rule must report the privilege fault. A stray request issued mid-fetch must leave the result, the read count and the later idle cycles unchanged. A design that restarted the fetch or queued the request would show extra reads or a second `done`.

// File: rtl/sel_translate_pkg.sv
package sel_translate_pkg;
  parameter int ADDR_W     = 24;
  parameter int SEL_W      = 16;
  parameter int OFF_W      = 16;
  parameter int WORD_W     = 16;
  parameter int DESC_WORDS = 4;
  localparam int IDX_W     = SEL_W - 3;
  localparam int CNT_W     = $clog2(DESC_WORDS);
  localparam int ENTRY_SH  = $clog2(DESC_WORDS * WORD_W / 8);

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_PRIV  = 2'd1,
    FLT_LIMIT = 2'd2,
    FLT_SEL   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_LAST} state_e;

  typedef struct packed {
    logic load;
    logic reject;
    logic issue;
    logic finish;
  } ctl_s;
endpackage

// File: rtl/sel_translate_ctrl.sv
module sel_translate_ctrl
  import sel_translate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             preBad,
  output ctl_s             ctl,
  output logic [CNT_W-1:0] wordCnt,
  output logic             busy
);
  state_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          wordCnt <= '0;
          if (reqValid && !preBad) state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          wordCnt <= wordCnt + 1'b1;
          if (wordCnt == CNT_W'(DESC_WORDS - 1)) state <= ST_LAST;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load   = (state == ST_IDLE) && reqValid && !preBad;
    ctl.reject = (state == ST_IDLE) && reqValid && preBad;
    ctl.issue  = (state == ST_ISSUE);
    ctl.finish = (state == ST_LAST);
    busy       = (state != ST_IDLE);
  end
endmodule

// File: rtl/sel_translate_dp.sv
module sel_translate_dp
  import sel_translate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic [CNT_W-1:0]  wordCnt,
  input  logic [SEL_W-1:0]  selector,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        curPriv,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [IDX_W-1:0]  ldtLimit,
  input  logic [WORD_W-1:0] memData,
  output logic              preBad,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              done,
  output logic [1:0]        faultCode,
  output logic [ADDR_W-1:0] linAddr
);
  // incoming selector fields
  logic [IDX_W-1:0] inIdx;
  logic             inLocal;
  logic [1:0]       inRpl;

  // captured request
  logic [IDX_W-1:0] idxR;
  logic             localR;
  logic [1:0]       effPrivR;
  logic             wrR;
  logic [OFF_W-1:0] offR;

  // captured descriptor fields
  logic [WORD_W-1:0]        limR;
  logic [WORD_W-1:0]        baseLoR;
  logic [ADDR_W-WORD_W-1:0] baseHiR;
  logic [1:0]               dplR;
  logic                     wrOkR;

  logic             rdValid;
  logic [CNT_W-1:0] rdIdx;

  logic [ADDR_W-1:0] tblBase;
  logic [ADDR_W-1:0] segBase;
  logic              privBad;
  logic              limBad;

  always_comb begin
    inIdx   = selector[SEL_W-1:3];
    inLocal = selector[2];
    inRpl   = selector[1:0];
    preBad  = (!inLocal && (inIdx == '0)) || (inLocal && (inIdx > ldtLimit));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxR     <= '0;
      localR   <= 1'b0;
      effPrivR <= '0;
      wrR      <= 1'b0;
      offR     <= '0;
    end else if (ctl.load) begin
      idxR     <= inIdx;
      localR   <= inLocal;
      effPrivR <= (curPriv > inRpl) ? curPriv : inRpl;
      wrR      <= accWrite;
      offR     <= offset;
    end
  end

  always_comb begin
    tblBase = localR ? ldtBase : gdtBase;
    memReq  = ctl.issue;
    memAddr = tblBase
            + (ADDR_W'(idxR) << ENTRY_SH)
            + (ADDR_W'(wordCnt) << 1);
  end

  // returning read data lines up with the request of the previous cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdIdx   <= '0;
    end else begin
      rdValid <= ctl.issue;
      rdIdx   <= wordCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limR    <= '0;
      baseLoR <= '0;
      baseHiR <= '0;
      dplR    <= '0;
      wrOkR   <= 1'b0;
    end else if (rdValid) begin
      case (rdIdx)
        CNT_W'(0): limR    <= memData;
        CNT_W'(1): baseLoR <= memData;
        CNT_W'(2): begin
          baseHiR <= memData[ADDR_W-WORD_W-1:0];
          wrOkR   <= memData[9];
          dplR    <= memData[14:13];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    segBase = {baseHiR, baseLoR};
    privBad = (effPrivR > dplR) || (wrR && !wrOkR);
    limBad  = offR > limR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      faultCode <= FLT_NONE;
      linAddr   <= '0;
    end else begin
      done <= ctl.finish || ctl.reject;
      if (ctl.reject) begin
        faultCode <= FLT_SEL;
        linAddr   <= '0;
      end else if (ctl.finish) begin
        if (privBad) begin
          faultCode <= FLT_PRIV;
          linAddr   <= '0;
        end else if (limBad) begin
          faultCode <= FLT_LIMIT;
          linAddr   <= '0;
        end else begin
          faultCode <= FLT_NONE;
          linAddr   <= segBase + ADDR_W'(offR);
        end
      end
    end
  end
endmodule

// File: rtl/sel_translate.sv
module sel_translate
  import sel_translate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SEL_W-1:0]  selector,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        curPriv,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [IDX_W-1:0]  ldtLimit,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memData,
  output logic              done,
  output logic [1:0]        faultCode,
  output logic [ADDR_W-1:0] linAddr
);
  ctl_s             ctl;
  logic [CNT_W-1:0] wordCnt;
  logic             preBad;

  sel_translate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .preBad(preBad),
    .ctl(ctl), .wordCnt(wordCnt), .busy(busy)
  );

  sel_translate_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordCnt(wordCnt),
    .selector(selector), .offset(offset), .curPriv(curPriv),
    .accWrite(accWrite), .gdtBase(gdtBase), .ldtBase(ldtBase),
    .ldtLimit(ldtLimit), .memData(memData), .preBad(preBad),
    .memReq(memReq), .memAddr(memAddr), .done(done),
    .faultCode(faultCode), .linAddr(linAddr)
  );
endmodule

// File: rtl/sel_translate_chk.sv
module sel_translate_chk
  import sel_translate_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done,
  input logic [1:0]        faultCode,
  input logic [ADDR_W-1:0] linAddr
);
  a_r10_no_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  a_r2_read_only_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  a_r2_word_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> (memAddr == $past(memAddr) + ADDR_W'(2)));

  a_r5_fault_clears_addr: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCode != 2'd0) |-> (linAddr == '0));

  a_r8_sel_fault_skips_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCode == 2'd3) |-> !$past(busy));
endmodule

bind sel_translate sel_translate_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReq(memReq), .memAddr(memAddr),
  .done(done), .faultCode(faultCode), .linAddr(linAddr)
);

// File: tb/sel_translate_bench.sv
module sel_translate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] GDT_BASE = 24'h000000;
  localparam logic [23:0] LDT_BASE = 24'h000200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] selector = '0;
  logic [15:0] offset = '0;
  logic [1:0]  curPriv = '0;
  logic        accWrite = 1'b0;
  logic [23:0] gdtBase = GDT_BASE;
  logic [23:0] ldtBase = LDT_BASE;
  logic [12:0] ldtLimit = 13'd5;
  logic        busy, memReq, done;
  logic [23:0] memAddr, linAddr;
  logic [15:0] memData;
  logic [1:0]  faultCode;

  int checks = 0;
  int failures = 0;

  logic [15:0] mem [0:511];
  int          readTotal = 0;
  logic [23:0] rdAddr [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  sel_translate u_sel_translate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .selector(selector),
    .offset(offset), .curPriv(curPriv), .accWrite(accWrite),
    .gdtBase(gdtBase), .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .busy(busy), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .done(done), .faultCode(faultCode), .linAddr(linAddr)
  );

  always @(posedge clk) begin
    if (memReq) begin
      memData <= mem[memAddr[9:1]];
      rdAddr[readTotal % 8] <= memAddr;
      readTotal <= readTotal + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mkSel(input int idx, input bit loc, input int rpl);
    return 16'((idx << 3) | (int'(loc) << 2) | rpl);
  endfunction

  // R3 layout: w0 limit, w1 base low, w2 {dpl@14:13, wr@9, base hi@7:0}, w3 unused
  task automatic setDesc(input logic [23:0] tbl, input int idx, input logic [23:0] base,
                         input logic [15:0] lim, input logic [1:0] dpl, input bit wr);
    int w;
    w = int'(tbl >> 1) + idx * 4;
    mem[w]     = lim;
    mem[w + 1] = base[15:0];
    mem[w + 2] = {1'b0, dpl, 3'b000, wr, 1'b0, base[23:16]};
    mem[w + 3] = 16'hDEAD;
  endtask

  task automatic run(input string tag, input logic [15:0] sel, input logic [15:0] off,
                     input logic [1:0] cpl, input bit wr, input logic [1:0] expFault,
                     input logic [23:0] expAddr, input int expLat, input int expReads,
                     input logic [23:0] expFirst);
    int snap;
    int lat;
    @(negedge clk);
    snap = readTotal;
    selector = sel; offset = off; curPriv = cpl; accWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " latency"}, lat, expLat);
    chk({tag, " fault"}, faultCode, expFault);
    chk({tag, " addr"}, linAddr, expAddr);
    chk({tag, " reads"}, readTotal - snap, expReads);
    if (expReads == 4)
      for (int k = 0; k < 4; k++)
        chk({tag, " read address"}, rdAddr[(snap + k) % 8], expFirst + 24'(2 * k));
  endtask

  task automatic testReset();
    chk("R12 busy", busy, 0);
    chk("R12 memReq", memReq, 0);
    chk("R12 done", done, 0);
    chk("R12 fault", faultCode, 0);
    chk("R12 addr", linAddr, 0);
  endtask

  task automatic testBasic();
    run("R1 R2 R4 R10 global", mkSel(1, 0, 0), 16'h0ABC, 2'd0, 0,
        2'd0, 24'h012DFC, 6, 4, GDT_BASE + 24'd8);
    run("R4 wrap", mkSel(2, 0, 3), 16'h0200, 2'd3, 1,
        2'd0, 24'h000100, 6, 4, GDT_BASE + 24'd16);
  endtask

  task automatic testLocalAndLimit();
    run("R1 R7 R9 local at limits", mkSel(5, 1, 2), 16'h2000, 2'd1, 1,
        2'd0, 24'h302000, 6, 4, LDT_BASE + 24'd40);
    run("R7 past limit", mkSel(5, 1, 2), 16'h2001, 2'd1, 0,
        2'd2, 24'h0, 6, 4, LDT_BASE + 24'd40);
  endtask

  task automatic testPrivilege();
    run("R5 via rpl", mkSel(3, 0, 1), 16'h0000, 2'd0, 0,
        2'd1, 24'h0, 6, 4, GDT_BASE + 24'd24);
    run("R5 via cpl", mkSel(3, 0, 0), 16'h0000, 2'd2, 0,
        2'd1, 24'h0, 6, 4, GDT_BASE + 24'd24);
    run("R5 allowed", mkSel(3, 0, 0), 16'h00FF, 2'd0, 0,
        2'd0, 24'h0500FF, 6, 4, GDT_BASE + 24'd24);
    run("R6 write read-only", mkSel(4, 0, 0), 16'h0010, 2'd0, 1,
        2'd1, 24'h0, 6, 4, GDT_BASE + 24'd32);
    run("R6 read read-only", mkSel(4, 0, 0), 16'h0010, 2'd0, 0,
        2'd0, 24'h000810, 6, 4, GDT_BASE + 24'd32);
  endtask

  task automatic testSelectorFaults();
    run("R8 null", mkSel(0, 0, 3), 16'h0000, 2'd0, 0, 2'd3, 24'h0, 1, 0, 24'h0);
    run("R9 local over", mkSel(6, 1, 0), 16'h0000, 2'd0, 0, 2'd3, 24'h0, 1, 0, 24'h0);
    run("R11 selector over privilege", mkSel(9, 1, 3), 16'hFFFF, 2'd3, 1,
        2'd3, 24'h0, 1, 0, 24'h0);
  endtask

  task automatic testPriority();
    run("R11 privilege over limit", mkSel(2, 1, 3), 16'h0020, 2'd0, 0,
        2'd1, 24'h0, 6, 4, LDT_BASE + 24'd16);
  endtask

  task automatic testIgnoreWhileBusy();
    int snap;
    int lat;
    int extra;
    @(negedge clk);
    snap = readTotal;
    selector = mkSel(1, 0, 0); offset = 16'h0000; curPriv = 2'd0; accWrite = 0;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R10 busy during fetch", busy, 1);
    selector = mkSel(0, 0, 0); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 3;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 ignored latency", lat, 6);
    chk("R10 ignored fault", faultCode, 0);
    chk("R10 ignored addr", linAddr, 24'h012340);
    chk("R10 ignored reads", readTotal - snap, 4);
    extra = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10 no second done", extra, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    setDesc(GDT_BASE, 1, 24'h012340, 16'h1000, 2'd3, 1);
    setDesc(GDT_BASE, 2, 24'hFFFF00, 16'hFFFF, 2'd3, 1);
    setDesc(GDT_BASE, 3, 24'h050000, 16'h00FF, 2'd0, 1);
    setDesc(GDT_BASE, 4, 24'h000800, 16'h0100, 2'd3, 0);
    setDesc(LDT_BASE, 5, 24'h300000, 16'h2000, 2'd2, 1);
    setDesc(LDT_BASE, 2, 24'h070000, 16'h0010, 2'd0, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testLocalAndLimit();
    testPrivilege();
    testSelectorFaults();
    testPriority();
    testIgnoreWhileBusy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule